// File: doc/BRIEF.md
# Switch-Controlled Running Light

This block turns an 8-bit bank of switches into an 8-bit LED pattern. In rotate mode a single lit bit walks around the port, left or right, wrapping from one end to the other. In table mode the port steps through one of two fixed sequences, a walking bit or a filling bar, each ending in an all-dark entry that closes the pass. The top switch acts as a run/pause switch, another switch picks the rotation direction, and the lowest switch picks the speed in rotate mode or the sequence in table mode.

All timing comes from a clock-enable input `tick_en`. A prescaler counts enabled cycles and emits one step per interval: a fast interval of `FAST_TICKS` ticks, or a slow one that is `SLOW_MULT` times longer. The LED register changes only on a step and holds its value in between. The switches and the LEDs are plain level signals: the block samples them when it needs them and drives its output continuously, so there is no handshake and no back-pressure at either edge.

Top module: `switch_chaser`

## Requirements
- R1: While `rst_n` is low, `led_out` is 0x00; the rotation register restarts at 0x01 and the table index at its first entry, so the first rotate step after reset shows 0x01.
- R2: While `sw_in[7]` is 0, no step occurs, `led_out` holds, and the interval counter clears, so after `sw_in[7]` returns to 1 a full interval passes before the next step.
- R3: Only cycles with `tick_en` high count; a step falls on every `FAST_TICKS`-th counted tick for the fast interval and on every `FAST_TICKS*SLOW_MULT`-th for the slow one. Table mode always uses the fast interval.
- R4: `mode_sel` (0 rotate, 1 table) and the speed switch `sw_in[0]` (1 fast, 0 slow) are captured at each step edge and continuously while paused; the captured values set the mode and the length of the interval that follows.
- R5: In rotate mode with `sw_in[6]` = 1, each step shows the current pattern and then rotates it one place towards the MSB, bit 7 wrapping into bit 0.
- R6: In rotate mode with `sw_in[6]` = 0, each step shows the current pattern and then rotates it one place towards the LSB, bit 0 wrapping into bit 7.
- R7: The direction switch is read at every step edge, so alternating it between steps alternates the rotation.
- R8: In table mode, `sw_in[0]` = 0 selects the walking sequence 01,02,04,08,10,20,40,80,00 and `sw_in[0]` = 1 the filling sequence 01,03,07,0F,1F,3F,7F,FF,00, one entry per step.
- R9: The sequence choice is read only on the step that shows a pass's first entry; changing `sw_in[0]` mid-pass has no effect until the step after the 00 entry.
- R10: Between steps `led_out` and the pattern state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Clock enable; each high cycle is one counted tick |
| mode_sel | input | 1 | 0 rotate mode, 1 table mode |
| sw_in | input | 8 | Switches: bit 7 run, bit 6 direction, bit 0 speed or sequence |
| led_out | output | 8 | Registered LED pattern |

## Verification
The hardest cases are switch edits landing one cycle after a step edge, where speed and mode apply to the interval after next but direction applies to the very next step, and a mode change at the end of a table pass. The bench reaches them by finishing every step check at the falling edge just after the step and changing the switches there, so the new values are in place for a whole interval before any further edge. Pausing mid-interval, sparse ticks, a sequence change in the middle of a pass and a return to rotate mode right after a 00 entry are driven the same way, with the expected pattern, interval and table entry computed arithmetically.

// File: rtl/chaser_pkg.sv
package chaser_pkg;
  typedef enum logic {MODE_ROTATE = 1'b0, MODE_TABLE = 1'b1} light_mode_e;
  typedef enum logic {SEQ_WALK = 1'b0, SEQ_FILL = 1'b1} light_seq_e;
endpackage

// File: rtl/chaser_prescaler.sv
module chaser_prescaler #(
  parameter int FAST_TICKS = 4,
  parameter int SLOW_MULT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic use_slow,
  output logic step
);
  localparam int SLOW_TICKS = FAST_TICKS * SLOW_MULT;
  localparam int CW = $clog2(SLOW_TICKS + 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = use_slow ? SLOW_LAST : FAST_LAST;
  assign step = run && tick_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick_en) cnt <= (cnt == last) ? '0 : cnt + CW'(1);
  end

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
  p_restart_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == '0));
  p_pause_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) && !step);
endmodule

// File: rtl/chaser_rotator.sv
module chaser_rotator #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             go_left,
  output logic [WIDTH-1:0] pattern
);
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) pattern <= SEED;
    else if (step) begin
      if (go_left) pattern <= {pattern[WIDTH-2:0], pattern[WIDTH-1]};
      else         pattern <= {pattern[0], pattern[WIDTH-1:1]};
    end
  end

  p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pattern) == 1);
  p_rot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pattern));
endmodule

// File: rtl/chaser_table.sv
module chaser_table
  import chaser_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  light_seq_e       seq_live,
  output logic [WIDTH-1:0] entry
);
  localparam int LEN = WIDTH + 1;
  localparam int IW = $clog2(LEN);
  localparam logic [IW-1:0] LAST = IW'(WIDTH);

  logic [IW-1:0]    idx;
  light_seq_e       seq_q;
  light_seq_e       seq_now;
  logic [WIDTH-1:0] walk_v;
  logic [WIDTH-1:0] fill_v;

  assign seq_now = (idx == '0) ? seq_live : seq_q;

  always_comb begin
    walk_v = '0;
    fill_v = '0;
    for (int k = 0; k < WIDTH; k++) begin
      walk_v[k] = (idx == IW'(k));
      fill_v[k] = (idx >= IW'(k)) && (idx != LAST);
    end
  end

  assign entry = (seq_now == SEQ_FILL) ? fill_v : walk_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      seq_q <= SEQ_WALK;
    end else if (step) begin
      if (idx == '0) seq_q <= seq_live;
      idx <= (idx == LAST) ? '0 : idx + IW'(1);
    end
  end

  p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);
  p_blank_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (entry == '0) |-> (idx == LAST));
  p_pass_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (idx == LAST)) |=> (idx == '0));
  p_seq_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0) |=> $stable(seq_q));
endmodule

// File: rtl/switch_chaser.sv
module switch_chaser
  import chaser_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int FAST_TICKS = 4,
  parameter int SLOW_MULT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             mode_sel,
  input  logic [WIDTH-1:0] sw_in,
  output logic [WIDTH-1:0] led_out
);
  localparam int RUN_BIT = WIDTH - 1;
  localparam int DIR_BIT = WIDTH - 2;
  localparam int SPD_BIT = 0;

  light_mode_e      mode_q;
  logic             fast_q;
  logic             step;
  logic             rot_step;
  logic             tbl_step;
  logic [WIDTH-1:0] rot_pat;
  logic [WIDTH-1:0] tbl_entry;
  logic             sw_unused;

  assign sw_unused = ^sw_in[DIR_BIT-1:SPD_BIT+1];
  assign rot_step  = step && (mode_q == MODE_ROTATE);
  assign tbl_step  = step && (mode_q == MODE_TABLE);

  chaser_prescaler #(.FAST_TICKS(FAST_TICKS), .SLOW_MULT(SLOW_MULT)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sw_in[RUN_BIT]),
    .tick_en  (tick_en),
    .use_slow ((mode_q == MODE_ROTATE) && !fast_q),
    .step     (step)
  );

  chaser_rotator #(.WIDTH(WIDTH)) u_rotator (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (rot_step),
    .go_left (sw_in[DIR_BIT]),
    .pattern (rot_pat)
  );

  chaser_table #(.WIDTH(WIDTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tbl_step),
    .seq_live (light_seq_e'(sw_in[SPD_BIT])),
    .entry    (tbl_entry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_ROTATE;
      fast_q  <= 1'b1;
      led_out <= '0;
    end else begin
      if (!sw_in[RUN_BIT] || step) begin
        mode_q <= light_mode_e'(mode_sel);
        fast_q <= sw_in[SPD_BIT];
      end
      if (step) led_out <= (mode_q == MODE_TABLE) ? tbl_entry : rot_pat;
    end
  end

  p_led_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(led_out));
  p_paused_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_in[RUN_BIT] |-> !step);
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_in[RUN_BIT] && !step) |=> $stable(mode_q) && $stable(fast_q));
  p_step_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(led_out));
endmodule

// File: tb/test_switch_chaser.sv
module test_switch_chaser;
  localparam int W  = 8;
  localparam int LF = 4;
  localparam int LS = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b1;
  logic         mode_sel = 1'b0;
  logic [W-1:0] sw_in = '0;
  logic [W-1:0] led_out;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int cyc = 0;
  logic [W-1:0] p = 8'h01;

  switch_chaser #(.WIDTH(W), .FAST_TICKS(4), .SLOW_MULT(4)) i_switch_chaser (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
    .sw_in(sw_in), .led_out(led_out)
  );

  always #5 clk = ~clk;

  initial forever begin
    @(negedge clk);
    cyc++;
    tick_en = ((cyc % tick_div) == 0);
  end

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction
  function automatic logic [W-1:0] rotr(input logic [W-1:0] v);
    return {v[0], v[W-1:1]};
  endfunction
  function automatic logic [W-1:0] tbl(input bit fill, input int k);
    if (k >= W) return '0;
    return fill ? W'((1 << (k + 1)) - 1) : W'(1 << k);
  endfunction

  task automatic check(input logic [W-1:0] exp, input string req);
    checks++;
    if (led_out !== exp) begin
      errors++;
      $display("FAIL %s: led_out=%02h expected=%02h", req, led_out, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (tick_en) c++;
    end
  endtask

  task automatic step_check(input int len, input logic [W-1:0] exp, input string req);
    logic [W-1:0] old;
    old = led_out;
    wait_ticks(len - 1);
    @(negedge clk);
    check(old, "R10 hold between steps");
    wait_ticks(1);
    @(negedge clk);
    check(exp, req);
  endtask

  task automatic rot_step(input int len, input bit left, input string req);
    step_check(len, p, req);
    p = left ? rotl(p) : rotr(p);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check(8'h00, "R1 reset value");
    sw_in = 8'h01;
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(8'h00, "R2 paused after reset");

    // R1 R5: left, fast, first shown value is the seed
    sw_in = 8'hC1;
    for (int i = 0; i < 10; i++) rot_step(LF, 1'b1, "R5 rotate left fast");

    // R2: pause mid-interval, then resume right and slow
    wait_ticks(2);
    @(negedge clk);
    sw_in = 8'h41;
    held = led_out;
    repeat (20) @(negedge clk);
    check(held, "R2 output frozen while paused");
    sw_in = 8'h00;
    @(negedge clk);
    sw_in = 8'h80;
    for (int i = 0; i < 9; i++) rot_step(LS, 1'b0, "R6 R3 rotate right slow");

    // R7: direction read at each step
    sw_in = 8'h01;
    @(negedge clk);
    sw_in = 8'hC1;
    for (int i = 0; i < 6; i++) begin
      rot_step(LF, (i % 2) == 0, "R7 direction per step");
      sw_in = ((i % 2) == 0) ? 8'h81 : 8'hC1;
    end

    // R4: speed edit after a step applies to the interval after next
    sw_in = 8'hC0;
    rot_step(LF, 1'b1, "R4 old speed kept for running interval");
    rot_step(LS, 1'b1, "R4 new speed after boundary");

    // R3: sparse ticks
    tick_div = 3;
    sw_in = 8'hC1;
    rot_step(LS, 1'b1, "R3 slow interval counts ticks only");
    rot_step(LF, 1'b1, "R3 fast interval counts ticks only");
    tick_div = 1;

    // R8: table mode, walking sequence, fast interval despite bit0=0
    sw_in = 8'h00;
    mode_sel = 1'b1;
    repeat (3) @(negedge clk);
    sw_in = 8'h80;
    for (int k = 0; k <= W; k++) step_check(LF, tbl(1'b0, k), "R8 walking table");
    // R9: mid-pass change ignored
    for (int k = 0; k < 3; k++) step_check(LF, tbl(1'b0, k), "R9 pass start");
    sw_in = 8'h81;
    for (int k = 3; k <= W; k++) step_check(LF, tbl(1'b0, k), "R9 mid-pass change ignored");
    for (int k = 0; k <= W; k++) step_check(LF, tbl(1'b1, k), "R8 R9 filling table next pass");

    // R4: mode change after the blank entry; one more table step, then rotate
    mode_sel = 1'b0;
    step_check(LF, tbl(1'b1, 0), "R4 mode captured at boundary");
    rot_step(LF, 1'b0, "R4 rotate resumes with kept pattern");
    rot_step(LF, 1'b0, "R6 rotate right after table");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule